// File: doc/BRIEF.md
# Transmit Frame Timing Generator

This block sets the frame timing for a serial transmit path that runs at either the DS3 or the E3 line rate. One bit is handled per cycle of the bit clock. A bit counter walks through the frame and an end-of-frame strobe goes high while the last bit is being handled. This lets the upstream payload source keep its transmission aligned to frame boundaries. The serial payload is captured on the rising clock edge. The source is expected to launch it on the falling edge.

The counter normally runs freely. When slave operation is enabled, the block follows an external frame reference that is synchronous to the bit clock. Each low-to-high transition of that reference restarts the frame at bit zero, so a system-level frame clock can re-align the framer at any point in a frame. A change of line format also restarts the count, so a partial frame is never closed with the wrong length.

Top module: `txf_timing_gen`

## Requirements
- R1: `eof` is high for exactly one clock cycle per frame, in the cycle where `bit_idx` holds the last index of the frame (length minus one).
- R2: With `mode_e3` = 0 (DS3) the frame is 4760 bits long, and with `mode_e3` = 1 (E3) it is 1536 bits long. `bit_idx` steps by one per cycle from 0 to length minus one and then wraps to 0.
- R3: With `slave_en` = 1, a cycle in which `frame_ref` is high after having been low in the previous cycle makes `bit_idx` 0 in the next cycle. Holding `frame_ref` high does not cause a further restart.
- R4: With `slave_en` = 0, `frame_ref` has no effect and the frame spacing stays at the nominal length.
- R5: A reference rising edge that arrives in the cycle where `bit_idx` is the last index produces a single restart. The next `eof` then follows exactly one frame length later, with no skipped frame and no extra strobe.
- R6: A change of `mode_e3` makes `bit_idx` 0 in the next cycle, and the following frame uses the new length.
- R7: While the synchronous active-high `rst` is asserted, `bit_idx` is 0, `eof` is 0 and `ser_out` is 0. The first cycle after release shows `bit_idx` = 1.
- R8: `ser_out` equals the value of `ser_in` sampled on the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_e3 | input | 1 | Line format: 0 selects DS3, 1 selects E3 |
| slave_en | input | 1 | 1 makes the counter follow `frame_ref` |
| frame_ref | input | 1 | External frame reference, synchronous to `clk` |
| ser_in | input | 1 | Serial payload bit |
| eof | output | 1 | End-of-frame strobe, high on the last bit |
| bit_idx | output | 13 | Index of the bit currently being handled |
| ser_out | output | 1 | Registered serial payload bit |

## Verification
The hardest case to set up is a reference edge that lands in the same cycle as the last bit, because the natural wrap and the forced restart then coincide. The bench reaches it by watching for the strobe and raising the reference on that same falling edge. It then measures the gap to the next strobe, which must equal one plain frame. Late edges are produced the same way by counting cycles from the strobe, either one cycle short of the boundary or a short way into the frame, and each time the bench checks the zeroed index and the stretched spacing.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic {
    LINE_DS3 = 1'b0,
    LINE_E3  = 1'b1
  } line_fmt_e;

  function automatic int unsigned idx_width(input int unsigned len_a, input int unsigned len_b);
    int unsigned m;
    m = (len_a > len_b) ? len_a : len_b;
    return (m < 2) ? 1 : $clog2(m);
  endfunction
endpackage

// File: rtl/txf_edge_det.sv
module txf_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic sig_in,
  output logic rise
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_in;
  end

  assign rise = enable & sig_in & ~sig_q;
endmodule

// File: rtl/txf_fmt_watch.sv
module txf_fmt_watch
  import txf_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_fmt_e fmt_in,
  output logic      changed
);
  line_fmt_e fmt_q;

  always_ff @(posedge clk) begin
    fmt_q <= fmt_in;
  end

  assign changed = ~rst & (fmt_in != fmt_q);
endmodule

// File: rtl/txf_frame_ctr.sv
module txf_frame_ctr
  import txf_pkg::*;
#(
  parameter int unsigned DS3_BITS = 4760,
  parameter int unsigned E3_BITS  = 1536,
  parameter int unsigned IDX_W    = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  line_fmt_e        fmt,
  input  logic             restart,
  output logic [IDX_W-1:0] idx,
  output logic             eof
);
  localparam logic [IDX_W-1:0] LAST_DS3 = IDX_W'(DS3_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_E3  = IDX_W'(E3_BITS - 1);

  logic [IDX_W-1:0] last_idx;
  logic [IDX_W-1:0] idx_nxt;

  always_comb begin
    last_idx = (fmt == LINE_E3) ? LAST_E3 : LAST_DS3;
    if (restart || idx == last_idx) idx_nxt = '0;
    else                            idx_nxt = idx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      eof <= 1'b0;
    end else begin
      idx <= idx_nxt;
      eof <= (idx_nxt == last_idx);
    end
  end
endmodule

// File: rtl/txf_data_pipe.sv
module txf_data_pipe #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage [STAGES+1];

  assign stage[0] = din;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[s+1] <= '0;
      else     stage[s+1] <= stage[s];
    end
  end

  assign dout = stage[STAGES];
endmodule

// File: rtl/txf_timing_gen.sv
module txf_timing_gen
  import txf_pkg::*;
#(
  parameter int unsigned DS3_BITS = 4760,
  parameter int unsigned E3_BITS  = 1536,
  parameter int unsigned DATA_LAT = 1,
  localparam int unsigned IDX_W   = idx_width(DS3_BITS, E3_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_e3,
  input  logic             slave_en,
  input  logic             frame_ref,
  input  logic             ser_in,
  output logic             eof,
  output logic [IDX_W-1:0] bit_idx,
  output logic             ser_out
);
  line_fmt_e fmt;
  logic      ref_rise;
  logic      fmt_changed;
  logic      restart;

  assign fmt     = line_fmt_e'(mode_e3);
  assign restart = ref_rise | fmt_changed;

  txf_edge_det u_ref_edge (
    .clk    (clk),
    .rst    (rst),
    .enable (slave_en),
    .sig_in (frame_ref),
    .rise   (ref_rise)
  );

  txf_fmt_watch u_fmt_watch (
    .clk     (clk),
    .rst     (rst),
    .fmt_in  (fmt),
    .changed (fmt_changed)
  );

  txf_frame_ctr #(
    .DS3_BITS (DS3_BITS),
    .E3_BITS  (E3_BITS),
    .IDX_W    (IDX_W)
  ) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .fmt     (fmt),
    .restart (restart),
    .idx     (bit_idx),
    .eof     (eof)
  );

  txf_data_pipe #(
    .WIDTH  (1),
    .STAGES (DATA_LAT)
  ) u_data (
    .clk  (clk),
    .rst  (rst),
    .din  (ser_in),
    .dout (ser_out)
  );
endmodule

// File: rtl/txf_timing_gen_chk.sv
module txf_timing_gen_chk #(
  parameter int unsigned DS3_BITS = 4760,
  parameter int unsigned E3_BITS  = 1536,
  parameter int unsigned IDX_W    = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             mode_e3,
  input logic             slave_en,
  input logic             frame_ref,
  input logic             ser_in,
  input logic             eof,
  input logic [IDX_W-1:0] bit_idx,
  input logic             ser_out
);
  localparam logic [IDX_W-1:0] LAST_DS3 = IDX_W'(DS3_BITS - 1);
  localparam logic [IDX_W-1:0] LAST_E3  = IDX_W'(E3_BITS - 1);

  logic [IDX_W-1:0] cur_last;
  assign cur_last = mode_e3 ? LAST_E3 : LAST_DS3;

  // R1: strobe only on a last index, never two cycles in a row
  p_eof_on_last_r1: assert property (@(posedge clk) disable iff (rst)
    eof |-> (bit_idx == LAST_DS3 || bit_idx == LAST_E3));
  p_eof_single_r1: assert property (@(posedge clk) disable iff (rst)
    eof |=> !eof);

  // R2: index stays inside the longer frame
  p_idx_bound_r2: assert property (@(posedge clk) disable iff (rst)
    bit_idx <= LAST_DS3);

  // R3: rising reference in slave mode restarts the frame
  p_ref_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (slave_en && $rose(frame_ref)) |=> (bit_idx == '0));

  // R4: free-running step is unaffected by the reference
  p_free_step_r4: assert property (@(posedge clk) disable iff (rst)
    (!slave_en && $stable(mode_e3) && bit_idx != cur_last)
      |=> (bit_idx == IDX_W'($past(bit_idx) + 1'b1)));

  // R6: format change restarts the count
  p_mode_restart_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_e3) |=> (bit_idx == '0));

  // R7: reset clears index and strobe
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (bit_idx == '0 && !eof && !ser_out));

  // R8: payload delayed by one clock
  p_data_delay_r8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (ser_out == $past(ser_in)));
endmodule

bind txf_timing_gen txf_timing_gen_chk #(
  .DS3_BITS (DS3_BITS),
  .E3_BITS  (E3_BITS),
  .IDX_W    (IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_e3   (mode_e3),
  .slave_en  (slave_en),
  .frame_ref (frame_ref),
  .ser_in    (ser_in),
  .eof       (eof),
  .bit_idx   (bit_idx),
  .ser_out   (ser_out)
);

// File: tb/txf_timing_gen_test.sv
module txf_timing_gen_test;
  localparam int DS3_LEN = 4760;
  localparam int E3_LEN  = 1536;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_e3 = 1'b0;
  logic        slave_en = 1'b0;
  logic        frame_ref = 1'b0;
  logic        ser_in = 1'b0;
  logic        eof;
  logic [12:0] bit_idx;
  logic        ser_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  txf_timing_gen uut (
    .clk       (clk),
    .rst       (rst),
    .mode_e3   (mode_e3),
    .slave_en  (slave_en),
    .frame_ref (frame_ref),
    .ser_in    (ser_in),
    .eof       (eof),
    .bit_idx   (bit_idx),
    .ser_out   (ser_out)
  );

  // fmt, slave, ref offset after a strobe (-1 = no pulse), expected strobe spacing
  typedef struct packed {
    logic fmt;
    logic slave;
    int   ofs;
    int   span;
    logic [7:0] tag;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0,   -1, 4760, 8'd2},  // R2 DS3 free run
    '{1'b1, 1'b0,   -1, 1536, 8'd2},  // R2 E3 free run
    '{1'b1, 1'b1,    0, 1536, 8'd5},  // R5 edge on last bit
    '{1'b1, 1'b1,  100, 1636, 8'd3},  // R3 edge early in frame
    '{1'b1, 1'b1, 1535, 3071, 8'd3},  // R3 edge just before boundary
    '{1'b0, 1'b1,    5, 4765, 8'd3},  // R3 DS3 re-align
    '{1'b0, 1'b0,   50, 4760, 8'd4},  // R4 reference ignored
    '{1'b1, 1'b0,  700, 1536, 8'd4}   // R4 reference ignored
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic fmt);
    @(negedge clk);
    rst = 1'b1;
    mode_e3 = fmt;
    frame_ref = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // returns cycles until eof seen (sampled at negedges)
  task automatic wait_eof(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!eof && cyc < 20000);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc;
    int len;

    // R7: reset state
    do_reset(1'b0);
    check(bit_idx == 0 && eof == 0 && ser_out == 0, "R7 reset state", int'(bit_idx), 0);
    @(negedge clk);
    check(bit_idx == 1, "R7 first count after release", int'(bit_idx), 1);

    // vector table
    for (int v = 0; v < NV; v++) begin
      len = VECS[v].fmt ? E3_LEN : DS3_LEN;
      slave_en = VECS[v].slave;
      do_reset(VECS[v].fmt);
      wait_eof(cyc);
      check(bit_idx == len - 1, "R1 eof on last index", int'(bit_idx), len - 1);
      cyc = 0;
      if (VECS[v].ofs == 0) frame_ref = 1'b1;
      do begin
        @(negedge clk);
        cyc++;
        if (cyc == 1) check(eof == 0, "R1 strobe one cycle", int'(eof), 0);
        if (VECS[v].slave && VECS[v].ofs >= 0 && cyc == VECS[v].ofs + 1)
          check(bit_idx == 0, "R3 restart to zero", int'(bit_idx), 0);
        frame_ref = (VECS[v].ofs >= 0 && cyc == VECS[v].ofs);
      end while (!eof && cyc < 20000);
      check(cyc == VECS[v].span, $sformatf("R%0d strobe spacing", VECS[v].tag), cyc, VECS[v].span);
    end

    // R3: level held high restarts only once
    slave_en = 1'b1;
    do_reset(1'b1);
    repeat (20) @(negedge clk);
    frame_ref = 1'b1;
    @(negedge clk);
    check(bit_idx == 0, "R3 restart on rise", int'(bit_idx), 0);
    repeat (5) @(negedge clk);
    check(bit_idx == 5, "R3 held level no restart", int'(bit_idx), 5);
    frame_ref = 1'b0;

    // R6: mode change mid-frame
    slave_en = 1'b0;
    do_reset(1'b0);
    repeat (300) @(negedge clk);
    mode_e3 = 1'b1;
    @(negedge clk);
    check(bit_idx == 0, "R6 restart on mode change", int'(bit_idx), 0);
    wait_eof(cyc);
    check(cyc == E3_LEN - 1, "R6 new length after change", cyc, E3_LEN - 1);
    mode_e3 = 1'b0;
    @(negedge clk);
    check(bit_idx == 0, "R6 restart back to DS3", int'(bit_idx), 0);
    wait_eof(cyc);
    check(cyc == DS3_LEN - 1, "R6 DS3 length after change", cyc, DS3_LEN - 1);

    // R8: payload delay
    for (int i = 0; i < 16; i++) begin
      logic b;
      b = logic'((i * 5 + 3) % 7 > 2);
      ser_in = b;
      @(negedge clk);
      check(ser_out == b, "R8 payload delay", int'(ser_out), int'(b));
    end

    // R7: reset mid-frame clears everything
    ser_in = 1'b1;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(bit_idx == 0 && eof == 0 && ser_out == 0, "R7 mid-run reset", int'(bit_idx) + int'(ser_out), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule